// File: doc/BRIEF.md
# Low-Speed USB Serial Receiver

This block recovers data bytes from a low-speed USB differential pair that is sampled by a much faster system clock. Both line inputs first pass through a synchroniser. The receiver waits until the bus sits at the idle level. It then hunts for the falling edge of D- that marks the sync field and locks its sample point near the centre of each bit. Sampling starts from that edge.

Once the sync field has ended, every sampled bit is NRZI-decoded and stuffed bits are removed. The data bits are packed into bytes, least-significant bit first. Each completed byte is presented for one cycle. When the line enters single-ended zero, the receiver reports the end of the packet together with the number of whole bytes received. It raises an abort pulse instead when a packet grows beyond the byte limit or carries an illegal run of ones.

The bit period is a fraction of the system clock (CLK_NUM/CLK_DEN clocks). A phase accumulator spreads the leftover fraction over the bits, so long and short periods alternate and the sample point does not drift across a maximum-length packet.

Top module: `usb_ls_rx`

## Requirements
- R1: After a synchronous reset, rx_valid, rx_eop and rx_abort are low, and rx_byte and rx_count are zero.
- R2: Both line inputs pass through a synchroniser. The line level is encoded as {D-, D+}: J = 2'b10 (idle), K = 2'b01 and SE0 = 2'b00. The receiver arms only after it has seen J, and it starts sync alignment on a J-to-K edge of D-.
- R3: The sync field ends when two consecutive bit samples after the edge are both K. If the second sample is J, the receiver returns to hunting for the next J-to-K edge. No byte is produced from an incomplete sync.
- R4: NRZI decoding uses the final K of the sync field as the reference level. A sampled level equal to the previous level decodes to 1, and a change of level decodes to 0.
- R5: After six consecutive decoded 1 bits, the next bit is a stuffed 0 and is dropped. The last bit of the sync field counts as the first 1 of such a run.
- R6: If the bit that follows six 1 bits decodes as 1, the receiver raises rx_abort for one cycle. It then ignores the line until SE0 appears.
- R7: Bytes are assembled LSb first. Each completed byte appears on rx_byte with rx_valid high for exactly one cycle.
- R8: A sample that reads SE0 ends reception at once. rx_eop pulses for one cycle, and rx_count gives the number of whole bytes. A partially received byte is discarded.
- R9: If byte number MAX_BYTES+1 completes, rx_abort pulses instead of rx_valid. No rx_eop follows for that packet.
- R10: Bits are sampled on a fractional period of CLK_NUM/CLK_DEN system clocks. No two sample strobes fall on adjacent cycles, and a full-length packet decodes without loss of alignment.
- R11: At most one of rx_valid, rx_eop and rx_abort is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| rx_eop | output | 1 | One-cycle end-of-packet pulse |
| rx_count | output | CNT_W | Whole bytes in the packet, valid with rx_eop |
| rx_abort | output | 1 | One-cycle pulse for overflow or stuffing violation |

## Verification
The bench builds line waveforms from byte lists using its own NRZI encoder and bit stuffer. Each waveform is driven at the fractional bit period.

- Mixed bytes show that bit order and NRZI polarity are correct.
- Runs of 0xFF force stuffed bits, which separates correct destuffing from a receiver that keeps or misplaces them.
- An unstuffed 0xFF run and a nine-byte packet trigger the two abort causes.
- A lone K pulse checks that a broken sync yields nothing, and that the receiver still locks onto the packet that follows.
- A trailing partial byte and an empty packet pin down the byte count reported at SE0.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

    // Line level as {D-, D+}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10,
        LN_SE1 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_WAIT_J,
        ST_HUNT,
        ST_SYNC,
        ST_RECV,
        ST_DRAIN
    } rx_state_t;

    localparam int RUN_LIMIT = 6;

    // Phase preload applied at the sync edge: half a bit plus the input latency.
    function automatic int phase_preload(int num, int den, int lat);
        int v;
        v = num / 2 + lat * den;
        if (v > num - 1) v = num - 1;
        return v;
    endfunction

endpackage

// File: rtl/usb_ls_rx_sync.sv
module usb_ls_rx_sync #(
    parameter int          STAGES = 2,
    parameter int          WIDTH  = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= INIT;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= INIT;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/usb_ls_rx_bittimer.sv
module usb_ls_rx_bittimer #(
    parameter int NUM  = 32,
    parameter int DEN  = 3,
    parameter int LOAD = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic strobe
);
    localparam int AW = $clog2(NUM + DEN + 1);

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;

    assign sum = acc + AW'(DEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            strobe <= 1'b0;
        end else if (restart) begin
            acc    <= AW'(LOAD);
            strobe <= 1'b0;
        end else if (sum >= AW'(NUM)) begin
            acc    <= sum - AW'(NUM);
            strobe <= 1'b1;
        end else begin
            acc    <= sum;
            strobe <= 1'b0;
        end
    end

    // R10: a bit lasts several clocks, so strobes are never back to back
    a_r10_strobe_gap: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

// File: rtl/usb_ls_rx_decode.sv
module usb_ls_rx_decode
    import usb_ls_rx_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sample,
    input  logic [1:0]       lvl,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             rx_eop,
    output logic [CNT_W-1:0] rx_count,
    output logic             rx_abort
);
    logic             prev_dm;
    logic [2:0]       ones;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] nbytes;
    logic             dbit;
    logic [7:0]       sh_next;

    assign dbit    = (lvl[1] == prev_dm);
    assign sh_next = {dbit, shreg[7:1]};

    always_ff @(posedge clk) begin
        rx_valid <= 1'b0;
        rx_eop   <= 1'b0;
        rx_abort <= 1'b0;
        if (rst) begin
            prev_dm  <= 1'b0;
            ones     <= '0;
            bitn     <= '0;
            shreg    <= '0;
            nbytes   <= '0;
            rx_byte  <= '0;
            rx_count <= '0;
        end else if (start) begin
            prev_dm <= 1'b0;          // last sync bit is K
            ones    <= 3'd1;          // and decodes as a 1
            bitn    <= '0;
            nbytes  <= '0;
        end else if (sample) begin
            if (lvl == LN_SE0) begin
                rx_eop   <= 1'b1;
                rx_count <= nbytes;
            end else begin
                prev_dm <= lvl[1];
                if (ones == 3'(RUN_LIMIT)) begin
                    if (dbit) rx_abort <= 1'b1;
                    else      ones     <= '0;
                end else begin
                    ones  <= dbit ? ones + 3'd1 : 3'd0;
                    shreg <= sh_next;
                    bitn  <= bitn + 3'd1;
                    if (bitn == 3'd7) begin
                        if (nbytes == CNT_W'(MAX_BYTES)) begin
                            rx_abort <= 1'b1;
                        end else begin
                            rx_valid <= 1'b1;
                            rx_byte  <= sh_next;
                            nbytes   <= nbytes + 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R5: the run of ones never passes the stuffing limit
    a_r5_run_bounded: assert property (@(posedge clk) disable iff (rst)
        ones <= 3'(RUN_LIMIT));
    // R9: the byte count stays within the configured limit
    a_r9_count_limit: assert property (@(posedge clk) disable iff (rst)
        nbytes <= CNT_W'(MAX_BYTES));
    // R8: a reported count never exceeds the limit
    a_r8_eop_count: assert property (@(posedge clk) disable iff (rst)
        rx_eop |-> rx_count <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int CLK_NUM     = 32,
    parameter int CLK_DEN     = 3,
    parameter int MAX_BYTES   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             usb_dp,
    input  logic             usb_dm,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             rx_eop,
    output logic [CNT_W-1:0] rx_count,
    output logic             rx_abort
);
    localparam int LOAD = phase_preload(CLK_NUM, CLK_DEN, SYNC_STAGES + 1);

    logic [1:0] lvl;
    logic       prev_dm;
    logic       edge_k;
    logic       strobe;
    logic       restart;
    logic       start;
    logic       sample;
    logic       first;
    rx_state_t  state;

    usb_ls_rx_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2),
        .INIT   (LN_J)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({usb_dm, usb_dp}),
        .d_out (lvl)
    );

    assign edge_k  = prev_dm && !lvl[1];
    assign restart = (state == ST_HUNT) && edge_k;
    assign start   = (state == ST_SYNC) && strobe && !first && (lvl == LN_K);
    assign sample  = (state == ST_RECV) && strobe;

    usb_ls_rx_bittimer #(
        .NUM  (CLK_NUM),
        .DEN  (CLK_DEN),
        .LOAD (LOAD)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .strobe  (strobe)
    );

    usb_ls_rx_decode #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W)
    ) u_dec (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sample   (sample),
        .lvl      (lvl),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_eop   (rx_eop),
        .rx_count (rx_count),
        .rx_abort (rx_abort)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT_J;
            prev_dm <= 1'b1;
            first   <= 1'b0;
        end else begin
            prev_dm <= lvl[1];
            unique case (state)
                ST_WAIT_J: if (lvl == LN_J) state <= ST_HUNT;
                ST_HUNT: if (edge_k) begin
                    state <= ST_SYNC;
                    first <= 1'b1;
                end
                ST_SYNC: if (strobe) begin
                    if (lvl == LN_SE0)      state <= ST_WAIT_J;
                    else if (lvl[1])        state <= ST_HUNT;
                    else if (first)         first <= 1'b0;
                    else                    state <= ST_RECV;
                end
                ST_RECV: begin
                    if (rx_abort)    state <= ST_DRAIN;
                    else if (rx_eop) state <= ST_WAIT_J;
                end
                ST_DRAIN: if (lvl == LN_SE0) state <= ST_WAIT_J;
                default: state <= ST_WAIT_J;
            endcase
        end
    end

    // R11: result pulses are mutually exclusive
    a_r11_one_hot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, rx_eop, rx_abort}));
    // R3: bytes only come out after a completed sync
    a_r3_valid_in_recv: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> state == ST_RECV);
    // R6: after an abort the receiver is silent until SE0
    a_r6_abort_drains: assert property (@(posedge clk) disable iff (rst)
        rx_abort |=> state == ST_DRAIN);
endmodule

// File: tb/tb_usb_ls_rx.sv
`timescale 1ns/1ps
module tb_usb_ls_rx;
    localparam int NUM = 32;
    localparam int DEN = 3;
    localparam int MAXB = 8;
    localparam int CW = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic usb_dp = 1'b0;
    logic usb_dm = 1'b1;
    logic [7:0]    rx_byte;
    logic          rx_valid, rx_eop, rx_abort;
    logic [CW-1:0] rx_count;

    usb_ls_rx #(.CLK_NUM(NUM), .CLK_DEN(DEN), .MAX_BYTES(MAXB)) dut (
        .clk(clk), .rst(rst), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_eop(rx_eop),
        .rx_count(rx_count), .rx_abort(rx_abort));

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    logic [7:0]  exp_q[$];
    int          exp_kind;   // 0 none, 1 eop, 2 abort
    int          exp_cnt;
    int          got_end;
    string       tag;
    logic [1:0]  lv[$];      // {dm,dp} per bit period

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: compares against the model on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (($countones({rx_valid, rx_eop, rx_abort})) != 0)
                check($countones({rx_valid, rx_eop, rx_abort}) == 1, "R11",
                      "pulses exclusive", int'({rx_valid, rx_eop, rx_abort}), 0);
            if (rx_valid) begin
                if (exp_q.size() == 0) check(0, tag, "unexpected byte", rx_byte, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_byte == e, tag, "R7 byte", rx_byte, e);
                end
            end
            if (rx_eop) begin
                check(exp_kind == 1 && got_end == 0, tag, "R8 eop expected", got_end, exp_kind);
                check(int'(rx_count) == exp_cnt, tag, "R8 count", rx_count, exp_cnt);
                got_end++;
            end
            if (rx_abort) begin
                check(exp_kind == 2 && got_end == 0, tag, "abort expected", got_end, exp_kind);
                got_end++;
            end
        end
    end

    task automatic push_lv(input logic [1:0] l, input int n);
        for (int i = 0; i < n; i++) lv.push_back(l);
    endtask

    // NRZI encode and stuff the bytes, plus extra zero bits
    task automatic build(input logic [7:0] bytes[$], input int extra, input bit stuff_on);
        logic [1:0] cur;
        int ones;
        bit bits[$];
        lv.delete();
        push_lv(2'b10, 4);
        for (int i = 0; i < 3; i++) begin push_lv(2'b01, 1); push_lv(2'b10, 1); end
        push_lv(2'b01, 2);
        cur = 2'b01;
        ones = 1;
        foreach (bytes[i]) for (int b = 0; b < 8; b++) bits.push_back(bytes[i][b]);
        for (int i = 0; i < extra; i++) bits.push_back(1'b0);
        foreach (bits[i]) begin
            if (stuff_on && ones == 6) begin
                cur = ~cur; lv.push_back(cur); ones = 0;
            end
            if (bits[i]) begin lv.push_back(cur); ones++; end
            else begin cur = ~cur; lv.push_back(cur); ones = 0; end
        end
        push_lv(2'b00, 2);
        push_lv(2'b10, 4);
    endtask

    task automatic drive();
        int c = 0;
        foreach (lv[i]) begin
            int e;
            e = ((i + 1) * NUM) / DEN;
            {usb_dm, usb_dp} = lv[i];
            while (c < e) begin @(negedge clk); c++; end
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic run_pkt(input string t, input logic [7:0] bytes[$], input int extra,
                           input bit stuff_on, input int kind, input int nexp);
        tag = t;
        exp_q.delete();
        for (int i = 0; i < nexp; i++) exp_q.push_back(bytes[i]);
        exp_kind = kind;
        exp_cnt = nexp;
        got_end = 0;
        build(bytes, extra, stuff_on);
        drive();
        check(exp_q.size() == 0, t, "bytes left", exp_q.size(), 0);
        check(got_end == (kind != 0 ? 1 : 0), t, "end events", got_end, kind != 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        exp_kind = 0; got_end = 0; tag = "R1";
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!rx_valid && !rx_eop && !rx_abort, "R1", "pulses", {rx_valid, rx_eop, rx_abort}, 0);
        check(rx_byte == 0 && rx_count == 0, "R1", "data", rx_byte, 0);

        // R4 R7 mixed bytes, R2 normal arming
        run_pkt("R4", '{8'hA5, 8'h3C, 8'h01}, 0, 1, 1, 3);
        // R5 stuffing runs
        run_pkt("R5", '{8'hFF, 8'hFF, 8'h7E}, 0, 1, 1, 3);
        // R10 full-length packet
        run_pkt("R10", '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'h55, 8'hAA, 8'h00, 8'h80}, 0, 1, 1, 8);
        // R9 overflow: nine bytes, eight delivered then abort
        run_pkt("R9", '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99},
                0, 1, 2, 8);
        // R6 stuffing violation
        run_pkt("R6", '{8'hFF, 8'hFF}, 0, 0, 2, 0);

        // R3 broken sync: lone K then idle, nothing may come out
        tag = "R3"; exp_q.delete(); exp_kind = 0; got_end = 0;
        lv.delete();
        push_lv(2'b10, 4); push_lv(2'b01, 1); push_lv(2'b10, 6);
        drive();
        check(got_end == 0, "R3", "no event on broken sync", got_end, 0);
        // R2 receiver still locks after the broken sync
        run_pkt("R2", '{8'hC3}, 0, 1, 1, 1);

        // R8 partial byte discarded, and an empty packet
        run_pkt("R8", '{8'h12}, 3, 1, 1, 1);
        run_pkt("R8", '{}, 0, 1, 1, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule